// File: doc/BRIEF.md
# Random-Spaced Picket One-Shot

This block places fence-picket marks along a scrolling track so that the gap between neighbouring pickets is uneven. A track-position strobe arrives at regular intervals. Each accepted strobe starts a 4-bit up-counting one-shot, and the counter's start value comes from a small circulating random word. The counter advances only on pixel-enable strobes. When it passes its terminal count of 15, a single-cycle picket pulse is produced. The offset of each picket therefore depends on both the strobe position and the random word.

Each accepted strobe rotates the random word by one bit, so the same word keeps producing a repeating pattern of four offsets while the current picket is on screen. When the display logic reports that the picket has scrolled off, the word is replaced. Four fresh bits are shifted in serially from an external random bit source. During that reload the block ignores strobes and ignores further off-screen reports.

Top module: `picket_oneshot`

## Requirements
- R1: Reset clears the one-shot, holds `picket` low and sets the random word to 4'b1011. No pulse appears until an accepted trigger has been followed by enough pixel-enable strobes.
- R2: An accepted trigger with word value S loads S as the count. The counter then rises by one on each pixel-enable strobe. On the strobe that finds the count at 15, `picket` goes high for exactly one clock in the next cycle. So the pulse follows the (16-S)-th strobe after the trigger, and S=0 gives 16 strobes.
- R3: While `pix_en` is low, the count holds and no pulse is produced.
- R4: Each accepted trigger rotates the word left by one bit, with the MSB moving into the LSB. The next shot uses the rotated value.
- R5: Without an off-screen report, the word returns to its original value after four accepted triggers.
- R6: In the cycle `offscreen` is sampled high (while no reload is running), the block starts a reload. On each of the next 4 clocks, `rnd_bit` enters at the LSB and the rest of the word shifts up. The first bit sampled ends up as the MSB.
- R7: A trigger in the `offscreen` cycle or during any of the 4 reload cycles is ignored. It neither starts a shot nor rotates the word.
- R8: An `offscreen` report during a reload is ignored and does not lengthen or restart the reload.
- R9: If an accepted trigger arrives in the same cycle that a running shot times out, the pulse is still produced and the new shot starts from the current word.
- R10: A trigger accepted while a shot is running restarts the count from the current word. The earlier shot produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-enable strobe that advances the one-shot |
| trig | input | 1 | Track-position trigger pulse |
| offscreen | input | 1 | Current picket has left the screen; request a new random word |
| rnd_bit | input | 1 | Serial bit from the external random source |
| picket | output | 1 | Picket line pulse, one clock wide |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a shot timing out and a new trigger being accepted. The bench schedules a trigger on exactly the clock the running shot reaches 15. It expects both the timeout pulse and a second pulse, spaced by the new start value. The second pair is a trigger and a reload start or reload step. The bench holds `trig` high through the `offscreen` cycle and the whole reload, and also raises `offscreen` again mid-reload. It then treats any extra pulse, or a wrongly timed later pulse, as a failure, because a later shot's timing reveals the loaded word.

// File: rtl/picket_oneshot.sv
module picket_oneshot #(
  parameter int W = 4,
  parameter logic [W-1:0] SEED = W'(11)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic trig,
  input  logic offscreen,
  input  logic rnd_bit,
  output logic picket
);
  localparam logic [W-1:0] TOP = '1;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  cnt, word;
  logic [CW-1:0] ldc;
  logic          active, loading;

  wire acc_trig = trig & ~loading & ~offscreen;
  wire start_ld = offscreen & ~loading;
  wire timeout  = active & pix_en & (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      picket <= 1'b0;
    end else begin
      picket <= timeout;
      if (acc_trig) begin
        cnt    <= word;
        active <= 1'b1;
      end else if (timeout) begin
        active <= 1'b0;
      end else if (active && pix_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word    <= SEED;
      loading <= 1'b0;
      ldc     <= '0;
    end else begin
      if (loading)
        word <= {word[W-2:0], rnd_bit};
      else if (acc_trig)
        word <= {word[W-2:0], word[W-1]};
      if (start_ld) begin
        loading <= 1'b1;
        ldc     <= '0;
      end else if (loading) begin
        ldc <= ldc + 1'b1;
        if (ldc == LAST) loading <= 1'b0;
      end
    end
  end

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    picket |-> $past(pix_en && active)); // R2
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !trig) |=> !picket); // R2
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !acc_trig) |=> $stable(cnt)); // R3
  AST_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !acc_trig) |=> $stable(word)); // R5
  AST_LOAD_BLOCKS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && trig && !active) |=> !active); // R7
  AST_LOAD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && offscreen && ldc != LAST) |=> (ldc == $past(ldc) + 1'b1)); // R8
endmodule

// File: tb/picket_oneshot_bench.sv
module picket_oneshot_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b1, trig = 1'b0, offscreen = 1'b0, rnd_bit = 1'b0;
  logic picket;
  int cyc = 0;
  int checks = 0, failures = 0;
  int expq[$];
  logic [3:0] mword = 4'b1011;
  int pend = -1;
  bit done = 0;
  bit reported = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  picket_oneshot u_picket_oneshot (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .trig(trig),
    .offscreen(offscreen), .rnd_bit(rnd_bit), .picket(picket)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && picket) begin
      if (expq.size() == 0)
        check(1'b0, "R2/R7 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = expq.pop_front();
        check(e == cyc, "R2/R4/R9/R10 pulse cycle", cyc, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire();
    int k;
    k = cyc + 1;
    if (pend > k) begin
      void'(expq.pop_back());  // R10 restart cancels the running shot
    end
    pend = k + 16 - int'(mword);
    expq.push_back(pend);
    mword = {mword[2:0], mword[3]};  // R4
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic stall_shot();
    int s;
    s = int'(mword);
    mword = {mword[2:0], mword[3]};
    pix_en = 1'b0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    idle(20);
    check(expq.size() == 0, "R3 no pulse while stalled", expq.size(), 0);
    expq.push_back(cyc + 1 + 15 - s);
    pix_en = 1'b1;
    idle(25);
    pend = -1;
  endtask

  task automatic reload(input logic [3:0] bits, input bit jam);
    offscreen = 1'b1;
    trig = jam;  // R7 trigger in the offscreen cycle
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      offscreen = jam && (i == 1);  // R8
      trig = jam;                   // R7
      rnd_bit = bits[i];
      @(negedge clk);
    end
    offscreen = 1'b0;
    trig = 1'b0;
    mword = {bits[0], bits[1], bits[2], bits[3]};  // R6
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(picket == 1'b0, "R1 idle after reset", picket, 0);
    end
    repeat (4) begin fire(); idle(20); end   // R2 R4
    fire(); idle(20);                         // R5 back to seed
    fire(); idle(3); fire(); idle(20);        // R10
    fire(); idle(2); fire(); idle(20);        // R9
    stall_shot();                             // R3
    reload(4'b0110, 1'b1); idle(6);           // R6 R7 R8
    fire(); idle(20); fire(); idle(20);
    reload(4'b1111, 1'b0); idle(2);
    fire(); idle(6);
    reload(4'b0000, 1'b0); idle(2);
    fire(); idle(25);
    check(expq.size() == 0, "R2 all expected pulses seen", expq.size(), 0);
    done = 1;
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    #200000;
    if (!done && !reported) begin
      check(1'b0, "watchdog", cyc, 0);
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule